// File: doc/BRIEF.md
# Read-Path Width Upsizer with Padding Strip

This block joins a narrow memory-mapped read requester (the left side) to a read target whose data bus is a power-of-two multiple wider (the right side). A left read request that starts or ends partway through a wide word is widened to a burst that covers whole wide words. The extra narrow lanes this brings in are dropped on the way back, so the left side receives exactly the beats it asked for, with its own last flag.

For every accepted request the block works out two figures. The first is how many narrow lanes of padding lie in the first wide word before the start address. The second is how many lie in the final wide word after the end address. It issues one aligned incrementing burst of the resulting wide length and queues both figures. Returning wide beats are unpacked in ascending lane order. Leading lanes of the first wide beat and trailing lanes of the last wide beat are skipped, and the last flag moves from the wide beat onto the final real narrow beat.

Read data must come back in request order because the padding figures are held in a queue. The block therefore lets several requests be in flight only when they share one ID. A request with another ID waits until every earlier burst has been delivered.

Top module: `rd_upsizer`

## Requirements
- R1: The right request address is the left address with its low log2(wide bytes) bits cleared. The right size code is log2(wide bytes), the right burst code is incrementing (2'b01), and the right ID equals the left ID.
- R2: With P = (left address mod wide bytes) / narrow bytes and N = left length + 1, the right length field is ceil((P + N) / ratio) − 1.
- R3: Narrow beats carry the wide-beat lanes in ascending order, with lane k in data bits [k·NARROW_W +: NARROW_W]. The first beat of a burst is lane P of the first wide beat, so leading padding lanes never reach the left side.
- R4: Exactly N narrow beats are delivered per burst. The left last flag is high only on the N-th beat, which comes from the final wide beat, so trailing padding lanes are dropped.
- R5: Each narrow beat carries the ID and response code of the wide beat it was taken from.
- R6: The right ready is high only in a cycle where the left side accepts the final real lane of the current wide beat. It stays low otherwise, including while the left ready is low.
- R7: A request whose burst code is not incrementing (2'b01), or whose size code is not log2(narrow bytes), is neither accepted on the left nor forwarded on the right while it is presented.
- R8: Further requests with the same ID as the bursts in flight are forwarded at once. A request with a different ID is held until all earlier bursts have delivered their final narrow beat.
- R9: At most FIFO_DEPTH bursts are in flight. Further requests are held until one completes.
- R10: During and right after reset, nothing is in flight: left read valid, right read ready and right request valid are all low when no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sArValid | input | 1 | Left request valid |
| sArReady | output | 1 | Left request ready |
| sArId | input | ID_W | Left request ID |
| sArAddr | input | ADDR_W | Left request byte address |
| sArLen | input | LEN_W | Left request length (beats − 1) |
| sArSize | input | 3 | Left request size code |
| sArBurst | input | 2 | Left request burst code |
| mArValid | output | 1 | Right request valid |
| mArReady | input | 1 | Right request ready |
| mArId | output | ID_W | Right request ID |
| mArAddr | output | ADDR_W | Right request aligned address |
| mArLen | output | LEN_W | Right request length (wide beats − 1) |
| mArSize | output | 3 | Right request size code |
| mArBurst | output | 2 | Right request burst code |
| mRValid | input | 1 | Right read data valid |
| mRReady | output | 1 | Right read data ready |
| mRId | input | ID_W | Right read ID |
| mRData | input | WIDE_W | Right read data |
| mRResp | input | 2 | Right read response |
| mRLast | input | 1 | Right read last beat |
| sRValid | output | 1 | Left read data valid |
| sRReady | input | 1 | Left read data ready |
| sRId | output | ID_W | Left read ID |
| sRData | output | NARROW_W | Left read data |
| sRResp | output | 2 | Left read response |
| sRLast | output | 1 | Left read last beat |

## Verification
The bench issues requests at every starting lane of a wide word, with lengths chosen so the span ends exactly on a boundary or leaves one to three trailing lanes. An aligned multi-word burst, a single beat at the top lane, a single beat at an interior lane with padding on both sides, and a maximum-length burst separate errors in leading skip, trailing skip, last-flag placement and length rounding. A throttled left ready pattern checks that a wide beat is consumed only on its final real lane. Held responses combined with same-ID, different-ID, illegal-code and queue-full requests tell apart the acceptance rules.

// File: rtl/rd_upsizer_pkg.sv
package rd_upsizer_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;

  // Head-of-queue padding figures offered by control to the datapath.
  typedef struct packed {
    logic       avail;
    logic [7:0] startLane;
    logic [7:0] endPad;
  } headInfo_t;

endpackage

// File: rtl/rd_upsizer_ctrl.sv
module rd_upsizer_ctrl
  import rd_upsizer_pkg::*;
#(
  parameter int NARROW_W   = 32,
  parameter int WIDE_W     = 128,
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sArValid,
  output logic              sArReady,
  input  logic [ID_W-1:0]   sArId,
  input  logic [ADDR_W-1:0] sArAddr,
  input  logic [LEN_W-1:0]  sArLen,
  input  logic [2:0]        sArSize,
  input  logic [1:0]        sArBurst,
  output logic              mArValid,
  input  logic              mArReady,
  output logic [ID_W-1:0]   mArId,
  output logic [ADDR_W-1:0] mArAddr,
  output logic [LEN_W-1:0]  mArLen,
  output logic [2:0]        mArSize,
  output logic [1:0]        mArBurst,
  output headInfo_t         head,
  input  logic              burstDone
);

  localparam int NB_LOG = $clog2(NARROW_W / 8);
  localparam int WB_LOG = $clog2(WIDE_W / 8);
  localparam int R_LOG  = WB_LOG - NB_LOG;
  localparam int SUM_W  = LEN_W + R_LOG + 1;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << WB_LOG) - 1);

  logic [R_LOG-1:0] startPad, endPad;
  logic [SUM_W-1:0] sumBeats, paddedBeats;
  logic             idOk, hasRoom, legal, gate, push;

  logic [R_LOG-1:0] startQ [FIFO_DEPTH];
  logic [R_LOG-1:0] endQ   [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [ID_W-1:0]  lastId;

  // Padding and wide length for the request on the port.
  always_comb begin
    startPad    = sArAddr[WB_LOG-1:NB_LOG];
    sumBeats    = SUM_W'(startPad) + SUM_W'(sArLen) + SUM_W'(1);
    endPad      = '0 - sumBeats[R_LOG-1:0];
    paddedBeats = sumBeats + SUM_W'(endPad);
  end

  // Acceptance gating.
  always_comb begin
    idOk     = (count == '0) || (sArId == lastId);
    hasRoom  = count < CNT_W'(FIFO_DEPTH);
    legal    = (sArBurst == BURST_INCR) && (sArSize == 3'(NB_LOG));
    gate     = legal && idOk && hasRoom;
    mArValid = sArValid && gate;
    sArReady = mArReady && gate;
    push     = sArValid && sArReady;
  end

  assign mArId    = sArId;
  assign mArAddr  = sArAddr & ~LOW_MASK;
  assign mArLen   = LEN_W'((paddedBeats >> R_LOG) - SUM_W'(1));
  assign mArSize  = 3'(WB_LOG);
  assign mArBurst = BURST_INCR;

  // Padding queue.
  always_ff @(posedge clk) begin
    if (push) begin
      startQ[wrPtr] <= startPad;
      endQ[wrPtr]   <= endPad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      lastId <= '0;
    end else begin
      if (push) begin
        wrPtr  <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        lastId <= sArId;
      end
      if (burstDone)
        rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, burstDone})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    head.avail     = (count != '0);
    head.startLane = 8'(startQ[rdPtr]);
    head.endPad    = 8'(endQ[rdPtr]);
  end

endmodule

// File: rtl/rd_upsizer_dp.sv
module rd_upsizer_dp
  import rd_upsizer_pkg::*;
#(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 128,
  parameter int ID_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  headInfo_t           head,
  output logic                burstDone,
  input  logic                mRValid,
  output logic                mRReady,
  input  logic [ID_W-1:0]     mRId,
  input  logic [WIDE_W-1:0]   mRData,
  input  logic [1:0]          mRResp,
  input  logic                mRLast,
  output logic                sRValid,
  input  logic                sRReady,
  output logic [ID_W-1:0]     sRId,
  output logic [NARROW_W-1:0] sRData,
  output logic [1:0]          sRResp,
  output logic                sRLast
);

  localparam int RATIO = WIDE_W / NARROW_W;
  localparam int R_LOG = $clog2(RATIO);

  logic [NARROW_W-1:0] laneWords [RATIO];
  logic [7:0]          lane, effLane, endLane;
  logic                midBurst, finalLane, xfer;

  for (genvar g = 0; g < RATIO; g++) begin : gLane
    assign laneWords[g] = mRData[g*NARROW_W +: NARROW_W];
  end

  always_comb begin
    effLane   = midBurst ? lane : head.startLane;
    endLane   = mRLast ? (8'(RATIO - 1) - head.endPad) : 8'(RATIO - 1);
    finalLane = (effLane == endLane);
    sRValid   = mRValid && head.avail;
    sRData    = laneWords[effLane[R_LOG-1:0]];
    sRId      = mRId;
    sRResp    = mRResp;
    sRLast    = mRLast && finalLane;
    xfer      = sRValid && sRReady;
    mRReady   = xfer && finalLane;
    burstDone = xfer && sRLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane     <= '0;
      midBurst <= 1'b0;
    end else if (xfer) begin
      if (finalLane) begin
        lane     <= '0;
        midBurst <= !mRLast;
      end else begin
        lane     <= effLane + 8'd1;
        midBurst <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rd_upsizer.sv
module rd_upsizer
  import rd_upsizer_pkg::*;
#(
  parameter int NARROW_W   = 32,
  parameter int WIDE_W     = 128,
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sArValid,
  output logic                sArReady,
  input  logic [ID_W-1:0]     sArId,
  input  logic [ADDR_W-1:0]   sArAddr,
  input  logic [LEN_W-1:0]    sArLen,
  input  logic [2:0]          sArSize,
  input  logic [1:0]          sArBurst,
  output logic                mArValid,
  input  logic                mArReady,
  output logic [ID_W-1:0]     mArId,
  output logic [ADDR_W-1:0]   mArAddr,
  output logic [LEN_W-1:0]    mArLen,
  output logic [2:0]          mArSize,
  output logic [1:0]          mArBurst,
  input  logic                mRValid,
  output logic                mRReady,
  input  logic [ID_W-1:0]     mRId,
  input  logic [WIDE_W-1:0]   mRData,
  input  logic [1:0]          mRResp,
  input  logic                mRLast,
  output logic                sRValid,
  input  logic                sRReady,
  output logic [ID_W-1:0]     sRId,
  output logic [NARROW_W-1:0] sRData,
  output logic [1:0]          sRResp,
  output logic                sRLast
);

  headInfo_t head;
  logic      burstDone;

  rd_upsizer_ctrl #(
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .ADDR_W(ADDR_W),
    .ID_W(ID_W), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .sArValid(sArValid), .sArReady(sArReady), .sArId(sArId),
    .sArAddr(sArAddr), .sArLen(sArLen), .sArSize(sArSize), .sArBurst(sArBurst),
    .mArValid(mArValid), .mArReady(mArReady), .mArId(mArId),
    .mArAddr(mArAddr), .mArLen(mArLen), .mArSize(mArSize), .mArBurst(mArBurst),
    .head(head), .burstDone(burstDone)
  );

  rd_upsizer_dp #(
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .ID_W(ID_W)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .head(head), .burstDone(burstDone),
    .mRValid(mRValid), .mRReady(mRReady), .mRId(mRId), .mRData(mRData),
    .mRResp(mRResp), .mRLast(mRLast),
    .sRValid(sRValid), .sRReady(sRReady), .sRId(sRId), .sRData(sRData),
    .sRResp(sRResp), .sRLast(sRLast)
  );

endmodule

// File: rtl/rd_upsizer_chk.sv
module rd_upsizer_chk
  import rd_upsizer_pkg::*;
#(
  parameter int NARROW_W   = 32,
  parameter int WIDE_W     = 128,
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sArValid,
  input logic              sArReady,
  input logic [ID_W-1:0]   sArId,
  input logic [ADDR_W-1:0] sArAddr,
  input logic [LEN_W-1:0]  sArLen,
  input logic [1:0]        sArBurst,
  input logic              mArValid,
  input logic [ADDR_W-1:0] mArAddr,
  input logic [LEN_W-1:0]  mArLen,
  input logic              mRReady,
  input logic [ID_W-1:0]   mRId,
  input logic [1:0]        mRResp,
  input logic              mRLast,
  input logic              sRValid,
  input logic              sRReady,
  input logic [ID_W-1:0]   sRId,
  input logic [1:0]        sRResp,
  input logic              sRLast
);

  localparam int NB_LOG = $clog2(NARROW_W / 8);
  localparam int WB_LOG = $clog2(WIDE_W / 8);
  localparam int R_LOG  = WB_LOG - NB_LOG;
  localparam int RATIO  = 1 << R_LOG;

  logic [15:0]     capBeats, needBeats;
  logic [ADDR_W-1:0] addrGap;
  logic [7:0]      outst;
  logic [ID_W-1:0] prevId;
  logic            arHs, doneHs;

  always_comb begin
    addrGap   = sArAddr - mArAddr;
    capBeats  = (16'(mArLen) + 16'd1) << R_LOG;
    needBeats = 16'(addrGap >> NB_LOG) + 16'(sArLen) + 16'd1;
    arHs      = sArValid && sArReady;
    doneHs    = sRValid && sRReady && sRLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst  <= '0;
      prevId <= '0;
    end else begin
      if (arHs) prevId <= sArId;
      case ({arHs, doneHs})
        2'b10:   outst <= outst + 8'd1;
        2'b01:   outst <= outst - 8'd1;
        default: outst <= outst;
      endcase
    end
  end

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mArValid |-> (mArAddr[WB_LOG-1:0] == '0) && (addrGap < ADDR_W'(1 << WB_LOG)));

  assert_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mArValid |-> (capBeats >= needBeats) && ((capBeats - needBeats) < 16'(RATIO)));

  assert_last_on_last_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sRValid && sRReady && sRLast) |-> (mRReady && mRLast));

  assert_attrs_copied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sRValid |-> (sRId == mRId) && (sRResp == mRResp));

  assert_consume_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mRReady |-> (sRValid && sRReady));

  assert_incr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sArValid && (sArBurst != BURST_INCR)) |-> (!sArReady && !mArValid));

  assert_id_throttle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arHs && (outst != 8'd0)) |-> (sArId == prevId));

  assert_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outst >= 8'(FIFO_DEPTH)) |-> !sArReady);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outst == 8'd0) |-> !sRValid);

endmodule

bind rd_upsizer rd_upsizer_chk #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .ADDR_W(ADDR_W),
  .ID_W(ID_W), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)
) uChk (
  .clk(clk), .rst_n(rst_n),
  .sArValid(sArValid), .sArReady(sArReady), .sArId(sArId), .sArAddr(sArAddr),
  .sArLen(sArLen), .sArBurst(sArBurst),
  .mArValid(mArValid), .mArAddr(mArAddr), .mArLen(mArLen),
  .mRReady(mRReady), .mRId(mRId), .mRResp(mRResp), .mRLast(mRLast),
  .sRValid(sRValid), .sRReady(sRReady), .sRId(sRId), .sRResp(sRResp), .sRLast(sRLast)
);

// File: tb/tb_rd_upsizer.sv
`timescale 1ns/1ps
module tb_rd_upsizer;

  localparam int NW = 32, WW = 128, AW = 32, IW = 4, LW = 8, DEPTH = 4;
  localparam int RATIO = WW / NW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sArValid = 1'b0, sArReady;
  logic [IW-1:0] sArId = '0;
  logic [AW-1:0] sArAddr = '0;
  logic [LW-1:0] sArLen = '0;
  logic [2:0] sArSize = 3'd2;
  logic [1:0] sArBurst = 2'b01;
  logic mArValid, mArReady = 1'b1;
  logic [IW-1:0] mArId;
  logic [AW-1:0] mArAddr;
  logic [LW-1:0] mArLen;
  logic [2:0] mArSize;
  logic [1:0] mArBurst;
  logic mRValid = 1'b0, mRReady;
  logic [IW-1:0] mRId = '0;
  logic [WW-1:0] mRData = '0;
  logic [1:0] mRResp = '0;
  logic mRLast = 1'b0;
  logic sRValid, sRReady = 1'b1;
  logic [IW-1:0] sRId;
  logic [NW-1:0] sRData;
  logic [1:0] sRResp;
  logic sRLast;

  always #4 clk = ~clk;

  rd_upsizer #(.NARROW_W(NW), .WIDE_W(WW), .ADDR_W(AW), .ID_W(IW),
               .LEN_W(LW), .FIFO_DEPTH(DEPTH)) dut (.*);

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit throttle = 1'b0, slvHold = 1'b0;

  // Expected left-side bursts.
  int unsigned expAddr [64];
  int          expBeats[64], expPad[64];
  logic [IW-1:0] expId [64];
  int expWr = 0, expRd = 0, curBeat = 0;

  // Right-side requests captured by the target model.
  int unsigned slvAddr[64];
  int          slvLen [64];
  logic [IW-1:0] slvId [64];
  int slvWr = 0, slvRd = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Right request capture.
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && mArValid && mArReady) begin
      slvAddr[slvWr % 64] = mArAddr;
      slvLen [slvWr % 64] = int'(mArLen);
      slvId  [slvWr % 64] = mArId;
      slvWr++;
    end
  end

  // Right read data model: lane k of wide beat b holds its own byte address.
  initial forever begin
    @(negedge clk);
    if (!slvHold && slvRd != slvWr) begin
      for (int b = 0; b <= slvLen[slvRd % 64]; b++) begin
        mRValid = 1'b1;
        mRId    = slvId[slvRd % 64];
        mRResp  = {b[0], slvId[slvRd % 64][0]};
        mRLast  = (b == slvLen[slvRd % 64]);
        for (int k = 0; k < RATIO; k++)
          mRData[k*NW +: NW] = slvAddr[slvRd % 64] + b * (WW / 8) + k * (NW / 8);
        forever begin
          #2;
          if (mRReady) break;
          @(negedge clk);
        end
        @(negedge clk);
      end
      mRValid = 1'b0;
      mRLast  = 1'b0;
      slvRd++;
    end
  end

  // Left read monitor.
  initial begin
    int cyc, q, pos;
    bit fin;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      sRReady = throttle ? (cyc % 3 != 1) : 1'b1;
      #2;
      if (rst_n) begin
        if (sRValid && sRReady) begin
          if (expRd == expWr) chk(1'b0, "R4 unexpected beat", sRData, 0);
          else begin
            q   = expRd % 64;
            pos = expPad[q] + curBeat;
            fin = (curBeat == expBeats[q] - 1) || (pos % RATIO == RATIO - 1);
            chk(sRData == expAddr[q] + curBeat * (NW / 8), "R3 lane data",
                sRData, expAddr[q] + curBeat * (NW / 8));
            chk(sRLast == (curBeat == expBeats[q] - 1), "R4 last flag",
                sRLast, curBeat == expBeats[q] - 1);
            chk(sRId == expId[q], "R5 id", sRId, expId[q]);
            chk(sRResp == {pos[R_BIT()], expId[q][0]}, "R5 resp", sRResp,
                {pos[R_BIT()], expId[q][0]});
            chk(mRReady == fin, "R6 wide consume", mRReady, fin);
            curBeat++;
            if (curBeat == expBeats[q]) begin
              curBeat = 0;
              expRd++;
            end
          end
        end else chk(mRReady == 1'b0, "R6 no consume without take", mRReady, 0);
      end
    end
  end

  function automatic int R_BIT();
    return $clog2(RATIO);
  endfunction

  // Presents a request until accepted, checking the forwarded fields.
  task automatic issue(input logic [IW-1:0] id, input int unsigned addr, input int len);
    int pad, wide, guard;
    pad  = (addr % (WW / 8)) / (NW / 8);
    wide = (pad + len + 1 + RATIO - 1) / RATIO;
    @(negedge clk);
    sArValid = 1'b1; sArId = id; sArAddr = addr; sArLen = LW'(len);
    sArSize = 3'd2; sArBurst = 2'b01;
    guard = 0;
    forever begin
      #2;
      if (sArValid && sArReady) break;
      guard++;
      if (guard > 3000) begin
        chk(1'b0, "R8 request never accepted", 0, 1);
        break;
      end
      @(negedge clk);
    end
    chk(mArValid == 1'b1, "R1 right valid", mArValid, 1);
    chk(mArAddr == (addr & ~32'hF), "R1 aligned addr", mArAddr, addr & ~32'hF);
    chk(mArSize == 3'd4 && mArBurst == 2'b01, "R1 size/burst", {mArSize, mArBurst}, {3'd4, 2'b01});
    chk(mArId == id, "R1 id", mArId, id);
    chk(int'(mArLen) == wide - 1, "R2 wide length", mArLen, wide - 1);
    expAddr[expWr % 64] = addr; expBeats[expWr % 64] = len + 1;
    expPad[expWr % 64] = pad;   expId[expWr % 64] = id;
    expWr++;
    @(negedge clk);
    sArValid = 1'b0;
  endtask

  task automatic waitDrain();
    int guard;
    guard = 0;
    while (expRd != expWr && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(expRd == expWr, "R4 burst delivered", expRd, expWr);
  endtask

  task automatic holdCheck(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #2;
      chk(!sArReady && !mArValid, req, {sArReady, mArValid}, 0);
    end
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!sRValid && !mRReady && !mArValid, "R10 in reset", {sRValid, mRReady, mArValid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!sRValid && !mRReady && !mArValid, "R10 after reset", {sRValid, mRReady, mArValid}, 0);
  endtask

  task automatic testPadding();
    issue(4'd1, 32'h1000, 7);   waitDrain();   // aligned, two wide beats
    issue(4'd1, 32'h1004, 2);   waitDrain();   // lead 1, trail 0
    issue(4'd2, 32'h2008, 4);   waitDrain();   // lead 2, trail 1
    issue(4'd2, 32'h300C, 0);   waitDrain();   // single beat, top lane
    issue(4'd3, 32'h3104, 0);   waitDrain();   // single beat, interior lane
  endtask

  task automatic testThrottle();
    throttle = 1'b1;
    issue(4'd4, 32'h4004, 9);   waitDrain();
    throttle = 1'b0;
  endtask

  task automatic testLong();
    issue(4'd5, 32'h5004, 255); waitDrain();
  endtask

  task automatic testIllegal();
    @(negedge clk);
    sArValid = 1'b1; sArId = 4'd6; sArAddr = 32'h6000; sArLen = 8'd3;
    sArBurst = 2'b00; sArSize = 3'd2;
    holdCheck("R7 non-incr held", 4);
    @(negedge clk);
    sArBurst = 2'b01; sArSize = 3'd3;
    holdCheck("R7 wrong size held", 4);
    @(negedge clk);
    sArValid = 1'b0; sArSize = 3'd2;
    repeat (3) @(negedge clk);
    chk(expRd == expWr && !sRValid, "R7 nothing returned", sRValid, 0);
  endtask

  task automatic testIdThrottle();
    int guard;
    slvHold = 1'b1;
    issue(4'd3, 32'h7000, 3);
    issue(4'd3, 32'h7104, 1);
    @(negedge clk);
    sArValid = 1'b1; sArId = 4'd9; sArAddr = 32'h7208; sArLen = 8'd1;
    sArBurst = 2'b01; sArSize = 3'd2;
    holdCheck("R8 other id held", 5);
    slvHold = 1'b0;
    guard = 0;
    forever begin
      @(negedge clk); #2;
      if (sArReady || guard > 2000) break;
      guard++;
    end
    chk(expRd == expWr, "R8 earlier bursts done first", expRd, expWr);
    @(negedge clk);
    sArValid = 1'b0;
    expAddr[expWr % 64] = 32'h7208; expBeats[expWr % 64] = 2;
    expPad[expWr % 64] = 2; expId[expWr % 64] = 4'd9;
    expWr++;
    waitDrain();
  endtask

  task automatic testDepth();
    slvHold = 1'b1;
    for (int i = 0; i < DEPTH; i++) issue(4'd1, 32'h8000 + i * 32'h100, 1);
    @(negedge clk);
    sArValid = 1'b1; sArId = 4'd1; sArAddr = 32'h9000; sArLen = 8'd0;
    sArBurst = 2'b01; sArSize = 3'd2;
    holdCheck("R9 queue full held", 5);
    @(negedge clk);
    sArValid = 1'b0;
    slvHold = 1'b0;
    waitDrain();
    issue(4'd1, 32'h9000, 0);
    waitDrain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    testReset();
    testPadding();
    testThrottle();
    testLong();
    testIllegal();
    testIdThrottle();
    testDepth();
    repeat (5) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule